// File: doc/BRIEF.md
# Security-Aware Interrupt Register Bank

This block is the register file of a vectored interrupt controller. For each external interrupt it stores an enable bit, a pending bit, an active bit, a priority byte and a target bit that marks the interrupt as belonging to the secure or the non-secure world. Software reaches this state through a small register bus. Each request carries a byte address, an access size (byte, halfword or word) and a secure attribute. The enable, pending, priority and target state is also driven as flat vectors to a separate priority resolver. The exception logic sets pending bits directly and moves active bits through dedicated pulse inputs.

Each bitmap is shown through a set view and a clear view. Writing ones sets or clears bits, and writing zeros leaves them alone. A non-secure request cannot see or change anything that belongs to an interrupt owned by the secure world. A reduced profile shrinks the block: it allows at most 32 interrupts, keeps only 2 priority bits, and turns the active view and the type word into reserved space.

Top module: `intc_regbank`

## Requirements
- R1: After reset every enable, pending, active, target and priority bit is zero, and every register reads as zero.
- R2: Word-aligned views: set-enable at 0x100, clear-enable at 0x180, set-pending at 0x200, clear-pending at 0x280, with interrupt 32*w+b at bit b of word w. A 1 written to a set view sets the bit and a 1 written to a clear view clears it. A 0 changes nothing. Both views of a pair read the current state.
- R3: Size encoding is 0 = byte, 1 = halfword, 2 = word. Data sits in its natural byte lane, so in a bitmap view the first interrupt touched is the byte offset times 8. Lanes outside the access read as zero. A misaligned access or size code 3 reads zero and writes nothing.
- R4: Priorities use one byte per interrupt at 0x400 + n. The full profile keeps all 8 bits, and `irq_prio_o[8n+7:8n]` shows the byte.
- R5: In the reduced profile only priority bits [7:6] are stored. The other bits read as zero, both on the bus and on `irq_prio_o`.
- R6: The target view at 0x380 (bit layout as in R2, 1 = secure) is read and written by secure requests only. Non-secure requests read it as zero and their writes are ignored.
- R7: A non-secure request reads as zero, and cannot write, the enable, pending, active or priority field of any interrupt whose target bit is 1.
- R8: Interrupts numbered NUM_IRQ or higher read as zero and ignore writes.
- R9: Addresses outside the mapped views read as zero and ignore writes. In the reduced profile the active view at 0x300 and the type word at 0x000 are also reserved.
- R10: In the full profile the type word at 0x000 reads ceil(NUM_IRQ/32)-1 in bits [3:0] and ignores writes.
- R11: A pulse on `hw_pend_i[n]` sets pending bit n. Pulses on `act_set_i[n]` and `act_clr_i[n]` set and clear active bit n, and set wins over clear. The active view at 0x300 is read-only over the bus.
- R12: A read request gets `rsp_valid` with `rsp_rdata` one cycle later. A write gets no response. Output vectors follow a write one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Request comes from the secure world |
| req_addr | input | 12 | Byte address within the bank |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data in natural byte lanes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| hw_pend_i | input | NUM_IRQ | Hardware pending set pulses |
| act_set_i | input | NUM_IRQ | Active set pulses |
| act_clr_i | input | NUM_IRQ | Active clear pulses |
| irq_enable_o | output | NUM_IRQ | Enable vector |
| irq_pend_o | output | NUM_IRQ | Pending vector |
| irq_target_o | output | NUM_IRQ | Target vector, 1 = secure |
| irq_prio_o | output | 8*NUM_IRQ | Priority bytes |

## Verification
Directed sequences come first. They use word, halfword and byte writes whose lanes fall inside and outside the configured interrupt range, which separates a bit-per-interrupt offset scaling from a byte-per-interrupt one. They then repeat the same accesses as secure and as non-secure requests around an interrupt marked secure, which shows whether masking follows the target bit or the access attribute. A second instance in the reduced profile shares the bus, so every directed access also tests priority truncation and the reserved views. A seeded random phase then mixes sizes, misalignments, both attributes and every region, and compares each read and each output vector with a bench model built from the requirements.

// File: rtl/intc_rb_pkg.sv
package intc_rb_pkg;

   typedef enum logic [3:0] {
      RG_RSVD, RG_TYPE, RG_SETEN, RG_CLREN, RG_SETPD,
      RG_CLRPD, RG_ACT, RG_TGT, RG_PRIO
   } rb_region_e;

   typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_BAD} rb_size_e;

   typedef enum logic {BM_SETCLR, BM_PLAIN} rb_bmode_e;

   localparam int LANES = 4;

endpackage

// File: rtl/intc_rb_decode.sv
module intc_rb_decode import intc_rb_pkg::*; #(
   parameter bit FULL_PROFILE = 1'b1
) (
   input  logic [11:0]      addr,
   input  logic [1:0]       size,
   output rb_region_e       region,
   output logic [LANES-1:0] be,
   output logic [4:0]       widx,
   output logic [6:0]       pword
);

   logic aligned;

   always_comb begin
      unique case (rb_size_e'(size))
         SZ_WORD: aligned = (addr[1:0] == 2'b00);
         SZ_HALF: aligned = !addr[0];
         SZ_BYTE: aligned = 1'b1;
         default: aligned = 1'b0;
      endcase
   end

   always_comb begin
      be = '0;
      if (aligned) begin
         unique case (rb_size_e'(size))
            SZ_WORD: be = 4'hF;
            SZ_HALF: be = addr[1] ? 4'hC : 4'h3;
            default: be = 4'(1) << addr[1:0];
         endcase
      end
   end

   always_comb begin
      unique case (addr[11:7])
         5'd0:                   region = (addr[6:2] == 5'd0 && FULL_PROFILE) ? RG_TYPE : RG_RSVD;
         5'd2:                   region = RG_SETEN;
         5'd3:                   region = RG_CLREN;
         5'd4:                   region = RG_SETPD;
         5'd5:                   region = RG_CLRPD;
         5'd6:                   region = FULL_PROFILE ? RG_ACT : RG_RSVD;
         5'd7:                   region = RG_TGT;
         5'd8, 5'd9, 5'd10, 5'd11: region = RG_PRIO;
         default:                region = RG_RSVD;
      endcase
   end

   assign widx  = addr[6:2];
   assign pword = addr[8:2];

endmodule

// File: rtl/intc_rb_bitmap.sv
module intc_rb_bitmap import intc_rb_pkg::*; #(
   parameter int        N    = 32,
   parameter rb_bmode_e MODE = BM_SETCLR
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] wbit,
   input  logic [N-1:0] hw_set,
   input  logic [N-1:0] hw_clr,
   output logic [N-1:0] q
);

   logic [N-1:0] sw_n;
   logic [N-1:0] q_n;

   generate
      if (MODE == BM_SETCLR) begin : g_setclr
         always_comb
            sw_n = (q | (set_we ? (hit & wbit) : '0)) & ~(clr_we ? (hit & wbit) : '0);

         a_r2_ones_land: assert property (@(posedge clk) disable iff (!rst_n)
            (set_we && hw_clr == '0) |=> ((q & $past(hit & wbit)) == $past(hit & wbit)));
      end else begin : g_plain
         logic wen;
         assign wen = set_we | clr_we;
         always_comb
            sw_n = wen ? ((q & ~hit) | (hit & wbit)) : q;
      end
   endgenerate

   assign q_n = (sw_n & ~hw_clr) | hw_set;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_n;
   end

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we && hw_set == '0 && hw_clr == '0) |=> $stable(q));

endmodule

// File: rtl/intc_rb_prio.sv
module intc_rb_prio import intc_rb_pkg::*; #(
   parameter int N  = 32,
   parameter int PB = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [6:0]       pword,
   input  logic [LANES-1:0] be,
   input  logic [31:0]      wdata,
   input  logic [N-1:0]     perm,
   output logic [N*8-1:0]   prio_o,
   output logic [31:0]      rd_word
);

   logic [PB-1:0] pr_q  [N];
   logic [7:0]    pbyte [N];

   generate
      for (genvar i = 0; i < N; i++) begin : g_irq
         localparam int LANE = i % LANES;
         assign pbyte[i] = 8'(pr_q[i]) << (8 - PB);
         assign prio_o[i*8 +: 8] = pbyte[i];
         always_ff @(posedge clk) begin
            if (!rst_n)
               pr_q[i] <= '0;
            else if (we && int'(pword) == i / LANES && be[LANE] && perm[i])
               pr_q[i] <= wdata[LANE*8+7 -: PB];
         end
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < N; i++)
         if (int'(pword) == i / LANES && be[i % LANES] && perm[i])
            rd_word[(i % LANES)*8 +: 8] = pbyte[i];
   end

   a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(prio_o));

endmodule

// File: rtl/intc_regbank.sv
module intc_regbank import intc_rb_pkg::*; #(
   parameter int NUM_IRQ           = 32,
   parameter bit FULL_PROFILE      = 1'b1,
   parameter int PRIO_BITS_FULL    = 8,
   parameter int PRIO_BITS_REDUCED = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic                 req_secure,
   input  logic [11:0]          req_addr,
   input  logic [1:0]           req_size,
   input  logic [31:0]          req_wdata,
   output logic                 rsp_valid,
   output logic [31:0]          rsp_rdata,
   input  logic [NUM_IRQ-1:0]   hw_pend_i,
   input  logic [NUM_IRQ-1:0]   act_set_i,
   input  logic [NUM_IRQ-1:0]   act_clr_i,
   output logic [NUM_IRQ-1:0]   irq_enable_o,
   output logic [NUM_IRQ-1:0]   irq_pend_o,
   output logic [NUM_IRQ-1:0]   irq_target_o,
   output logic [NUM_IRQ*8-1:0] irq_prio_o
);

   localparam int NWORDS    = (NUM_IRQ + 31) / 32;
   localparam int PADN      = NWORDS * 32;
   localparam int PRIO_BITS = FULL_PROFILE ? PRIO_BITS_FULL : PRIO_BITS_REDUCED;

   generate
      if (NUM_IRQ < 1 || NUM_IRQ > 512) begin : g_bad_count
         $error("NUM_IRQ must lie in 1..512");
      end
      if (!FULL_PROFILE && NUM_IRQ > 32) begin : g_bad_reduced
         $error("reduced profile allows at most 32 interrupts");
      end
      if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
         $error("priority width must lie in 1..8");
      end
   endgenerate

   rb_region_e       region;
   logic [LANES-1:0] be;
   logic [4:0]       widx;
   logic [6:0]       pword;

   intc_rb_decode #(.FULL_PROFILE(FULL_PROFILE)) u_dec (
      .addr(req_addr), .size(req_size), .region(region),
      .be(be), .widx(widx), .pword(pword)
   );

   logic [NUM_IRQ-1:0] en_q, pd_q, act_q, tgt_q;
   logic [NUM_IRQ-1:0] perm, bit_hit, bit_wd;
   logic               wr;

   assign wr   = req_valid && req_write;
   assign perm = req_secure ? '1 : ~tgt_q;

   generate
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_hit
         assign bit_hit[i] = (int'(widx) == i / 32) && be[(i % 32) / 8] && perm[i];
         assign bit_wd[i]  = req_wdata[i % 32];
      end
   endgenerate

   intc_rb_bitmap #(.N(NUM_IRQ), .MODE(BM_SETCLR)) u_en (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr && region == RG_SETEN), .clr_we(wr && region == RG_CLREN),
      .hit(bit_hit), .wbit(bit_wd), .hw_set('0), .hw_clr('0), .q(en_q)
   );

   intc_rb_bitmap #(.N(NUM_IRQ), .MODE(BM_SETCLR)) u_pd (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr && region == RG_SETPD), .clr_we(wr && region == RG_CLRPD),
      .hit(bit_hit), .wbit(bit_wd), .hw_set(hw_pend_i), .hw_clr('0), .q(pd_q)
   );

   intc_rb_bitmap #(.N(NUM_IRQ), .MODE(BM_SETCLR)) u_act (
      .clk(clk), .rst_n(rst_n), .set_we(1'b0), .clr_we(1'b0),
      .hit(bit_hit), .wbit(bit_wd), .hw_set(act_set_i), .hw_clr(act_clr_i), .q(act_q)
   );

   intc_rb_bitmap #(.N(NUM_IRQ), .MODE(BM_PLAIN)) u_tgt (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr && region == RG_TGT && req_secure), .clr_we(1'b0),
      .hit(bit_hit), .wbit(bit_wd), .hw_set('0), .hw_clr('0), .q(tgt_q)
   );

   logic [31:0] prio_rd;

   intc_rb_prio #(.N(NUM_IRQ), .PB(PRIO_BITS)) u_prio (
      .clk(clk), .rst_n(rst_n), .we(wr && region == RG_PRIO),
      .pword(pword), .be(be), .wdata(req_wdata), .perm(perm),
      .prio_o(irq_prio_o), .rd_word(prio_rd)
   );

   logic [NUM_IRQ-1:0] src;
   logic [PADN-1:0]    vis_pad;
   logic [31:0]        bit_word, raw_word, lane_mask;

   always_comb begin
      unique case (region)
         RG_SETEN, RG_CLREN: src = en_q;
         RG_SETPD, RG_CLRPD: src = pd_q;
         RG_ACT:             src = act_q;
         RG_TGT:             src = tgt_q;
         default:            src = '0;
      endcase
      vis_pad  = PADN'(src & perm);
      bit_word = '0;
      for (int w = 0; w < NWORDS; w++)
         if (int'(widx) == w) bit_word = vis_pad[w*32 +: 32];
   end

   always_comb begin
      for (int k = 0; k < LANES; k++) lane_mask[k*8 +: 8] = {8{be[k]}};
      unique case (region)
         RG_PRIO: raw_word = prio_rd;
         RG_TYPE: raw_word = {28'd0, 4'(NWORDS - 1)};
         default: raw_word = bit_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         rsp_rdata <= (req_valid && !req_write) ? (raw_word & lane_mask) : '0;
      end
   end

   assign irq_enable_o = en_q;
   assign irq_pend_o   = pd_q;
   assign irq_target_o = tgt_q;

   a_r12_rsp_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   a_r6_ns_target_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_secure) |=> $stable(irq_target_o));

   a_r7_ns_enable_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_secure) |=>
         (((irq_enable_o ^ $past(irq_enable_o)) & $past(irq_target_o)) == '0));

   a_r11_active_bus_immune: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && act_set_i == '0 && act_clr_i == '0) |=> $stable(act_q));

endmodule

// File: tb/intc_regbank_test.sv
`timescale 1ns/1ps
module intc_regbank_test;

   localparam int NF = 40;
   localparam int NR = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic [NF-1:0] hw_pend = '0, act_set = '0, act_clr = '0;

   logic          rv_f, rv_r;
   logic [31:0]   rd_f, rd_r;
   logic [NF-1:0] en_f, pd_f, tg_f;
   logic [NF*8-1:0] pr_f;
   logic [NR-1:0] en_r, pd_r, tg_r;
   logic [NR*8-1:0] pr_r;

   intc_regbank #(.NUM_IRQ(NF), .FULL_PROFILE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rv_f), .rsp_rdata(rd_f),
      .hw_pend_i(hw_pend), .act_set_i(act_set), .act_clr_i(act_clr),
      .irq_enable_o(en_f), .irq_pend_o(pd_f), .irq_target_o(tg_f), .irq_prio_o(pr_f)
   );

   intc_regbank #(.NUM_IRQ(NR), .FULL_PROFILE(1'b0)) uut_rp (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rv_r), .rsp_rdata(rd_r),
      .hw_pend_i(hw_pend[NR-1:0]), .act_set_i(act_set[NR-1:0]), .act_clr_i(act_clr[NR-1:0]),
      .irq_enable_o(en_r), .irq_pend_o(pd_r), .irq_target_o(tg_r), .irq_prio_o(pr_r)
   );

   int n_chk = 0, n_fail = 0;
   logic [31:0] s_f, s_r;
   logic        sv_f, sv_r;

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic acc(input logic w, input logic s, input logic [11:0] a,
                      input logic [1:0] sz, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_secure = s;
      req_addr = a; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      sv_f = rv_f; s_f = rd_f; sv_r = rv_r; s_r = rd_r;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // bench model of the full-profile instance
   logic [NF-1:0] m_en, m_pd, m_act, m_tgt;
   logic [7:0]    m_pr [NF];

   task automatic m_dec(input logic [11:0] a, input logic [1:0] sz,
                        output int rg, output logic [3:0] be);
      logic ok;
      ok = (sz == 2) ? (a[1:0] == 0) : (sz == 1) ? !a[0] : (sz == 0);
      be = !ok ? 4'h0 : (sz == 2) ? 4'hF : (sz == 1) ? (a[1] ? 4'hC : 4'h3) : (4'h1 << a[1:0]);
      if (a[11:2] == 0) rg = 1;
      else if (a[11:7] >= 2 && a[11:7] <= 7) rg = int'(a[11:7]);
      else if (a[11:9] == 3'b010) rg = 8;
      else rg = 0;
   endtask

   function automatic logic mbit(input int rg, input int n);
      case (rg)
         2, 3:    return m_en[n];
         4, 5:    return m_pd[n];
         6:       return m_act[n];
         default: return m_tgt[n];
      endcase
   endfunction

   task automatic m_read(input logic [11:0] a, input logic [1:0] sz, input logic s,
                         output logic [31:0] r);
      int rg; logic [3:0] be;
      m_dec(a, sz, rg, be);
      r = '0;
      for (int k = 0; k < 4; k++) begin
         if (!be[k]) continue;
         if (rg == 1 && k == 0) r[3:0] = 4'd1;
         else if (rg >= 2 && rg <= 7) begin
            for (int b = 0; b < 8; b++) begin
               int n = int'(a[6:2]) * 32 + k * 8 + b;
               if (n < NF && (s || !m_tgt[n])) r[k*8+b] = mbit(rg, n);
            end
         end else if (rg == 8) begin
            int n = int'(a[8:2]) * 4 + k;
            if (n < NF && (s || !m_tgt[n])) r[k*8 +: 8] = m_pr[n];
         end
      end
   endtask

   task automatic m_write(input logic [11:0] a, input logic [1:0] sz, input logic s,
                          input logic [31:0] wd);
      int rg; logic [3:0] be; logic [NF-1:0] t;
      m_dec(a, sz, rg, be);
      t = m_tgt;
      for (int k = 0; k < 4; k++) begin
         if (!be[k]) continue;
         if (rg == 8) begin
            int n = int'(a[8:2]) * 4 + k;
            if (n < NF && (s || !t[n])) m_pr[n] = wd[k*8 +: 8];
         end else if (rg >= 2 && rg <= 7) begin
            for (int b = 0; b < 8; b++) begin
               int n = int'(a[6:2]) * 32 + k * 8 + b;
               logic v = wd[k*8+b];
               if (n >= NF || !(s || !t[n])) continue;
               case (rg)
                  2: if (v) m_en[n] = 1'b1;
                  3: if (v) m_en[n] = 1'b0;
                  4: if (v) m_pd[n] = 1'b1;
                  5: if (v) m_pd[n] = 1'b0;
                  7: if (s) m_tgt[n] = v;
                  default: ;
               endcase
            end
         end
      end
   endtask

   logic finished = 1'b0;

   initial begin
      #(8ns * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] e;
      logic [NF*8-1:0] ep;
      do_reset();
      // R1 reset state
      @(negedge clk);
      chk("R1 enable vector", 64'(en_f), 0);
      chk("R1 pending vector", 64'(pd_f), 0);
      chk("R1 target vector", 64'(tg_f), 0);
      chk("R1 prio vector low", pr_f[63:0], 0);
      acc(0, 1, 12'h100, 2, 0);
      chk("R1 set-enable read", s_f, 0);
      // R2 set/clear views, R12 response timing
      acc(1, 1, 12'h100, 2, 32'h8000_0005);
      chk("R12 no response to write", 64'(sv_f), 0);
      acc(0, 1, 12'h100, 2, 0);
      chk("R12 read response valid", 64'(sv_f), 1);
      chk("R2 set view", s_f, 32'h8000_0005);
      acc(0, 1, 12'h180, 2, 0);
      chk("R2 clear view reads state", s_f, 32'h8000_0005);
      chk("R2 enable output", 64'(en_f), 40'h00_8000_0005);
      acc(1, 1, 12'h180, 2, 32'h1);
      acc(1, 1, 12'h100, 2, 32'h0);
      acc(0, 1, 12'h100, 2, 0);
      chk("R2 clear one, zero no effect", s_f, 32'h8000_0004);
      chk("R2 reduced instance", s_r, 32'h8000_0004);
      // R3 sizes and lanes
      acc(1, 1, 12'h101, 0, 32'h0000_FF00);
      acc(0, 1, 12'h102, 1, 0);
      chk("R3 halfword upper lanes", s_f, 32'h8000_0000);
      acc(0, 1, 12'h100, 0, 0);
      chk("R3 byte lane 0", s_f, 32'h0000_0004);
      acc(1, 1, 12'h104, 0, 32'h0000_0001);
      acc(0, 1, 12'h104, 2, 0);
      chk("R3 irq 32 via byte write", s_f, 32'h1);
      acc(1, 1, 12'h102, 2, 32'hFFFF_FFFF);
      acc(0, 1, 12'h100, 2, 0);
      chk("R3 misaligned write ignored", s_f, 32'h8000_FF04);
      acc(0, 1, 12'h102, 2, 0);
      chk("R3 misaligned read zero", s_f, 0);
      acc(0, 1, 12'h100, 3, 0);
      chk("R3 size code 3 reads zero", s_f, 0);
      // R4 / R5 priority
      acc(1, 1, 12'h403, 0, 32'hA500_0000);
      acc(0, 1, 12'h400, 2, 0);
      chk("R4 prio byte irq3", s_f, 32'hA500_0000);
      chk("R4 prio output irq3", 64'(pr_f[31:24]), 8'hA5);
      chk("R5 reduced prio read", s_r, 32'h8000_0000);
      chk("R5 reduced prio output", 64'(pr_r[31:24]), 8'h80);
      acc(1, 1, 12'h424, 2, 32'h4433_2211);
      acc(0, 1, 12'h424, 2, 0);
      chk("R4 prio word irq36-39", s_f, 32'h4433_2211);
      chk("R8 reduced above range prio", s_r, 0);
      // R6 target view
      acc(1, 1, 12'h380, 2, 32'h8);
      acc(0, 1, 12'h380, 2, 0);
      chk("R6 secure target read", s_f, 32'h8);
      acc(0, 0, 12'h380, 2, 0);
      chk("R6 non-secure target read", s_f, 0);
      acc(1, 0, 12'h380, 2, 32'hFFFF_FFFF);
      chk("R6 non-secure target write ignored", 64'(tg_f), 40'h8);
      // R7 masking of secure-owned interrupt 3
      acc(1, 0, 12'h100, 2, 32'h8);
      acc(0, 1, 12'h100, 2, 0);
      chk("R7 ns set-enable ignored", s_f, 32'h8000_FF04);
      acc(1, 1, 12'h100, 2, 32'h8);
      acc(0, 0, 12'h100, 2, 0);
      chk("R7 ns read masks irq3", s_f, 32'h8000_FF04);
      acc(1, 0, 12'h180, 2, 32'hFFFF_FFFF);
      acc(0, 1, 12'h100, 2, 0);
      chk("R7 ns clear spares irq3", s_f, 32'h8);
      acc(1, 0, 12'h400, 2, 32'h1111_1111);
      acc(0, 1, 12'h400, 2, 0);
      chk("R7 ns prio write spares irq3", s_f, 32'hA511_1111);
      chk("R5 reduced drops low prio bits", s_r, 32'h8000_0000);
      acc(0, 0, 12'h400, 2, 0);
      chk("R7 ns prio read masks irq3", s_f, 32'h0011_1111);
      // R8 range
      acc(1, 1, 12'h104, 2, 32'hFFFF_FFFF);
      acc(0, 1, 12'h104, 2, 0);
      chk("R8 word 1 upper bits zero", s_f, 32'hFF);
      chk("R8 reduced word 1 zero", s_r, 0);
      acc(1, 1, 12'h108, 2, 32'hFFFF_FFFF);
      acc(0, 1, 12'h108, 2, 0);
      chk("R8 word 2 zero", s_f, 0);
      acc(1, 1, 12'h428, 0, 32'h77);
      acc(0, 1, 12'h428, 2, 0);
      chk("R8 prio irq40 zero", s_f, 0);
      // R9 / R10 reserved and type
      acc(1, 1, 12'h000, 2, 32'hFFFF_FFFF);
      acc(0, 1, 12'h000, 2, 0);
      chk("R10 type word full", s_f, 32'h1);
      chk("R9 type word reserved in reduced", s_r, 0);
      acc(1, 1, 12'h600, 2, 32'hFFFF_FFFF);
      acc(0, 1, 12'h600, 2, 0);
      chk("R9 reserved address", s_f, 0);
      // R11 hardware inputs
      @(negedge clk); hw_pend[5] = 1'b1;
      @(negedge clk); hw_pend[5] = 1'b0;
      acc(0, 1, 12'h200, 2, 0);
      chk("R11 hw pend sets bit", s_f, 32'h20);
      chk("R11 hw pend reduced", s_r, 32'h20);
      acc(1, 1, 12'h200, 2, 32'h100);
      acc(1, 1, 12'h280, 2, 32'h20);
      chk("R2 pending output", 64'(pd_f), 40'h100);
      @(negedge clk); act_set[7] = 1'b1;
      @(negedge clk); act_set[7] = 1'b0;
      acc(1, 1, 12'h300, 2, 32'h0);
      acc(1, 1, 12'h300, 2, 32'hFFFF_FFFF);
      acc(0, 1, 12'h300, 2, 0);
      chk("R11 active set, bus read-only", s_f, 32'h80);
      chk("R9 active view reserved in reduced", s_r, 0);
      @(negedge clk); act_set[9] = 1'b1; act_clr[9] = 1'b1; act_clr[7] = 1'b1;
      @(negedge clk); act_set = '0; act_clr = '0;
      acc(0, 1, 12'h300, 2, 0);
      chk("R11 active clear, set wins", s_f, 32'h200);

      // seeded random phase against the model
      do_reset();
      m_en = '0; m_pd = '0; m_act = '0; m_tgt = '0;
      for (int i = 0; i < NF; i++) m_pr[i] = '0;
      void'($urandom(32'd1234));
      for (int it = 0; it < 600; it++) begin
         logic [11:0] a; logic [1:0] sz; logic s, w; logic [31:0] wd;
         case ($urandom % 9)
            0: a = 12'(($urandom % 4));
            1: a = 12'h100 + 12'($urandom % 12);
            2: a = 12'h180 + 12'($urandom % 12);
            3: a = 12'h200 + 12'($urandom % 12);
            4: a = 12'h280 + 12'($urandom % 12);
            5: a = 12'h300 + 12'($urandom % 12);
            6: a = 12'h380 + 12'($urandom % 12);
            7: a = 12'h400 + 12'($urandom % 64);
            default: a = 12'h600 + 12'($urandom % 16);
         endcase
         sz = 2'($urandom % 4);
         s  = 1'($urandom % 2);
         w  = 1'($urandom % 2);
         wd = $urandom;
         if (w) begin
            acc(1, s, a, sz, wd);
            m_write(a, sz, s, wd);
            chk("R2 random enable vector", 64'(en_f), 64'(m_en));
            chk("R2 random pending vector", 64'(pd_f), 64'(m_pd));
            chk("R6 random target vector", 64'(tg_f), 64'(m_tgt));
            for (int n = 0; n < NF; n++) ep[n*8 +: 8] = m_pr[n];
            for (int c = 0; c < NF / 8; c++)
               chk("R4 random prio vector", pr_f[c*64 +: 64], ep[c*64 +: 64]);
         end else begin
            acc(0, s, a, sz, 0);
            m_read(a, sz, s, e);
            chk("R12 random read valid", 64'(sv_f), 1);
            chk("R7 random read data", s_f, e);
         end
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule